// File: doc/BRIEF.md
# Ethernet Back-off Slot Multiplier Generator

This block supplies the random multiplier used by truncated binary exponential back-off after a transmit collision. A maximal-length 10-bit linear feedback shift register runs on every clock and serves as the source of pseudo-random bits. The block works out the collision number n for the current frame, forms the exponent k = min(n, 10), and keeps only the k low-order bits of the shift register. The result is an integer r between 0 and 2^k − 1.

The collision number comes from one of two places. It can be presented on a 4-bit input by the transmit controller. It can also be counted inside the block from a collision pulse and a frame-done pulse. On a request, the block captures r and the product of r and a configurable slot time, then gives a one-cycle valid strobe. Once a frame has seen 16 collisions, the block flags an excessive-collision error and refuses to give any further back-off value for that frame.

The tracker state machine has three states. TRK_CLEAN means no collision has been seen yet for this frame. TRK_ACTIVE means 1 to 15 collisions have been seen. TRK_EXCESS means 16 collisions have been seen. The transitions are: clean-to-active on the first collision, active-to-active on further collisions, active-to-excess on the sixteenth collision, and any state to clean on frame done. The output state machine has two states. OUT_IDLE moves to OUT_STROBE on an accepted request. OUT_STROBE returns to OUT_IDLE, or stays in OUT_STROBE if another request is accepted.

Top module: `backoff_rng`

## Requirements
- R1: The random source is a 10-bit shift register that resets to 10'h001. On every clock edge out of reset it shifts left by one bit. The new bit 0 is the old bit 9 XOR the old bit 6, which is the polynomial x^10 + x^7 + 1. It never holds zero.
- R2: For collision number n, r equals the shift register value ANDed with 2^min(n,10) − 1. So r always lies in 0 to 2^k − 1, and r is 0 when n is 0.
- R3: When `track_i` is 0, the collision number is taken from `coll_cnt_i`, which carries n − 1. Codes 0 to 15 stand for n = 1 to 16.
- R4: When `track_i` is 1, the collision number is the internal count. That count is 0 after reset and rises by one on each `coll_pulse_i`, stopping at 16. `frame_done_i` clears it to 0 and wins over a collision pulse in the same cycle.
- R5: `exc_coll_o` is high in every cycle in which the selected collision number is 16 or more, with no delay.
- R6: A request made while `exc_coll_o` is high gives no valid strobe and leaves `r_o` and `backoff_o` unchanged.
- R7: A request accepted at a clock edge loads `r_o` at that edge and drives `valid_o` high for the cycle that follows. `r_o` then holds until the next accepted request.
- R8: `backoff_o` equals `r_o` times the `slot_time_i` value present at the accepting edge.
- R9: From n = 10 up to n = 15, the full range 0 to 1023 is available.
- R10: During and right after reset, `valid_o`, `r_o` and `backoff_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track_i | input | 1 | 1: use the internal collision count; 0: use `coll_cnt_i` |
| coll_cnt_i | input | 4 | External collision number minus one |
| coll_pulse_i | input | 1 | One collision seen for the current frame |
| frame_done_i | input | 1 | Current frame finished or abandoned; clears the count |
| req_i | input | 1 | Request a back-off value |
| slot_time_i | input | 16 | Slot time in clock ticks |
| r_o | output | 10 | Captured slot multiplier |
| backoff_o | output | 26 | Captured back-off time, r times slot time |
| valid_o | output | 1 | One-cycle strobe after an accepted request |
| exc_coll_o | output | 1 | Excessive-collision error for the current frame |

## Verification
A fault in the shift register shows up as a wrong `r_o` at the first request that follows, because the bench reference predicts the exact value in every cycle. A wrong tracker count shows up either as a mask that is too wide or too narrow, which is seen at the next request, or as `exc_coll_o` changing one collision early or late, which is seen in the same cycle. A fault in the output state machine shows up at once as a missing, extra or late `valid_o` cycle. A fault in the capture path shows up as `r_o` or `backoff_o` moving when no request has been accepted.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    typedef enum logic [1:0] {
        TRK_CLEAN  = 2'd0,
        TRK_ACTIVE = 2'd1,
        TRK_EXCESS = 2'd2
    } trk_state_t;

    typedef enum logic {
        OUT_IDLE   = 1'b0,
        OUT_STROBE = 1'b1
    } out_state_t;

endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr #(
    parameter int          WIDTH = 10,
    parameter int          TAP_HI = 9,
    parameter int          TAP_LO = 6,
    parameter logic [WIDTH-1:0] SEED = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value_o
);

    logic [WIDTH-1:0] shreg_q;
    logic [WIDTH-1:0] shreg_d;
    logic             fb_bit;

    always_comb begin
        fb_bit  = shreg_q[TAP_HI] ^ shreg_q[TAP_LO];
        shreg_d = {shreg_q[WIDTH-2:0], fb_bit};
        if (shreg_d == '0) begin
            shreg_d = SEED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= SEED;
        end else begin
            shreg_q <= shreg_d;
        end
    end

    assign value_o = shreg_q;

    // R1
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shreg_q != '0);

    // R1
    lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> shreg_q != $past(shreg_q));

endmodule

// File: rtl/backoff_count_trk.sv
module backoff_count_trk
    import backoff_pkg::*;
#(
    parameter int LIMIT = 16,
    parameter int N_W   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           coll_pulse_i,
    input  logic           frame_done_i,
    output logic [N_W-1:0] count_o
);

    trk_state_t     state_q, state_d;
    logic [N_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_CLEAN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (frame_done_i) begin
            state_d = TRK_CLEAN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TRK_CLEAN: begin
                    if (coll_pulse_i) begin
                        state_d = TRK_ACTIVE;
                        cnt_d   = N_W'(1);
                    end
                end
                TRK_ACTIVE: begin
                    if (coll_pulse_i) begin
                        cnt_d = cnt_q + N_W'(1);
                        if (cnt_q == N_W'(LIMIT - 1)) begin
                            state_d = TRK_EXCESS;
                        end
                    end
                end
                TRK_EXCESS: begin
                    cnt_d = N_W'(LIMIT);
                end
                default: begin
                    state_d = TRK_CLEAN;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        count_o = cnt_q;
    end

    // R4
    trk_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= N_W'(LIMIT));

    // R4
    trk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_i |=> count_o == '0);

endmodule

// File: rtl/backoff_range_mask.sv
module backoff_range_mask #(
    parameter int RW  = 10,
    parameter int N_W = 5
) (
    input  logic [N_W-1:0] n_i,
    input  logic [RW-1:0]  rand_i,
    output logic [RW-1:0]  mask_o,
    output logic [RW-1:0]  r_o
);

    for (genvar b = 0; b < RW; b++) begin : g_bit
        assign mask_o[b] = (32'(n_i) > b);
    end

    assign r_o = rand_i & mask_o;

endmodule

// File: rtl/backoff_rng.sv
module backoff_rng
    import backoff_pkg::*;
#(
    parameter int RW     = 10,
    parameter int CNT_W  = 4,
    parameter int SLOT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                track_i,
    input  logic [CNT_W-1:0]    coll_cnt_i,
    input  logic                coll_pulse_i,
    input  logic                frame_done_i,
    input  logic                req_i,
    input  logic [SLOT_W-1:0]   slot_time_i,
    output logic [RW-1:0]       r_o,
    output logic [RW+SLOT_W-1:0] backoff_o,
    output logic                valid_o,
    output logic                exc_coll_o
);

    localparam int N_W    = CNT_W + 1;
    localparam int LIMIT  = 1 << CNT_W;
    localparam int TIME_W = RW + SLOT_W;

    logic [RW-1:0]     rand_w;
    logic [N_W-1:0]    trk_n_w;
    logic [N_W-1:0]    n_sel;
    logic [RW-1:0]     mask_w;
    logic [RW-1:0]     r_masked;
    logic              accept;
    logic [TIME_W-1:0] prod_w;

    out_state_t        ost_q, ost_d;
    logic [RW-1:0]     r_q;
    logic [TIME_W-1:0] bo_q;

    backoff_lfsr #(
        .WIDTH (RW),
        .TAP_HI(9),
        .TAP_LO(6),
        .SEED  (RW'(1))
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .value_o(rand_w)
    );

    backoff_count_trk #(
        .LIMIT(LIMIT),
        .N_W  (N_W)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .coll_pulse_i(coll_pulse_i),
        .frame_done_i(frame_done_i),
        .count_o     (trk_n_w)
    );

    always_comb begin
        if (track_i) begin
            n_sel = trk_n_w;
        end else begin
            n_sel = {1'b0, coll_cnt_i} + N_W'(1);
        end
    end

    backoff_range_mask #(
        .RW (RW),
        .N_W(N_W)
    ) u_mask (
        .n_i   (n_sel),
        .rand_i(rand_w),
        .mask_o(mask_w),
        .r_o   (r_masked)
    );

    assign exc_coll_o = (n_sel >= N_W'(LIMIT));
    assign accept     = req_i && !exc_coll_o;
    assign prod_w     = TIME_W'(r_masked) * TIME_W'(slot_time_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ost_q <= OUT_IDLE;
            r_q   <= '0;
            bo_q  <= '0;
        end else begin
            ost_q <= ost_d;
            if (accept) begin
                r_q  <= r_masked;
                bo_q <= prod_w;
            end
        end
    end

    always_comb begin
        unique case (ost_q)
            OUT_IDLE:   ost_d = accept ? OUT_STROBE : OUT_IDLE;
            OUT_STROBE: ost_d = accept ? OUT_STROBE : OUT_IDLE;
            default:    ost_d = OUT_IDLE;
        endcase
    end

    always_comb begin
        valid_o   = (ost_q == OUT_STROBE);
        r_o       = r_q;
        backoff_o = bo_q;
    end

    // R2
    r_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (r_o & ~$past(mask_w)) == '0);

    // R7
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(req_i));

    // R6
    excess_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_coll_o |=> !valid_o && $stable(r_o));

    // R8
    product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> backoff_o == TIME_W'(r_o) * TIME_W'($past(slot_time_i)));

endmodule

// File: tb/backoff_rng_tb_top.sv
module backoff_rng_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        track_i;
    logic [3:0]  coll_cnt_i;
    logic        coll_pulse_i;
    logic        frame_done_i;
    logic        req_i;
    logic [15:0] slot_time_i;
    logic [9:0]  r_o;
    logic [25:0] backoff_o;
    logic        valid_o;
    logic        exc_coll_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    int m_lfsr, m_cnt, m_r, m_bo, m_vld;
    int seen_high;

    always #2 clk = ~clk;

    backoff_rng dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .track_i     (track_i),
        .coll_cnt_i  (coll_cnt_i),
        .coll_pulse_i(coll_pulse_i),
        .frame_done_i(frame_done_i),
        .req_i       (req_i),
        .slot_time_i (slot_time_i),
        .r_o         (r_o),
        .backoff_o   (backoff_o),
        .valid_o     (valid_o),
        .exc_coll_o  (exc_coll_o)
    );

    function automatic int n_now();
        return track_i ? m_cnt : int'(coll_cnt_i) + 1;
    endfunction

    function automatic int kexp(int n);
        return (n < 10) ? n : 10;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model update at each edge, from pre-edge state and stable inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr = 1; m_cnt = 0; m_r = 0; m_bo = 0; m_vld = 0;
        end else begin
            int n;
            n = n_now();
            if (req_i && n < 16) begin
                m_r   = m_lfsr & ((1 << kexp(n)) - 1);
                m_bo  = m_r * int'(slot_time_i);
                m_vld = 1;
                if (n >= 10 && m_r >= 512) seen_high++;
            end else begin
                m_vld = 0;
            end
            if (frame_done_i) m_cnt = 0;
            else if (coll_pulse_i && m_cnt < 16) m_cnt++;
            m_lfsr = ((m_lfsr << 1) & 1023) | (((m_lfsr >> 9) ^ (m_lfsr >> 6)) & 1);
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(valid_o == m_vld[0], "R7 valid_o", valid_o, m_vld);
            check(int'(r_o) == m_r, "R1/R2 r_o", r_o, m_r);
            check(int'(backoff_o) == m_bo, "R8 backoff_o", backoff_o, m_bo);
            check(exc_coll_o == (n_now() >= 16), "R5 exc_coll_o", exc_coll_o, n_now() >= 16);
            if (valid_o)
                check(int'(r_o) < 1024, "R2 r_o range", r_o, 1023);
        end
    end

    task automatic tick(input int cycles);
        repeat (cycles) @(posedge clk);
        #1;
    endtask

    task automatic pulse_req(input int slot);
        slot_time_i = 16'(slot);
        req_i = 1'b1;
        tick(1);
        req_i = 1'b0;
    endtask

    initial begin
        #150000;
        $display("FAIL watchdog expired actual=0 expected=1");
        errors++;
        checks++;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        seen_high = 0;
        rst_n = 1'b0; track_i = 1'b1; coll_cnt_i = '0; coll_pulse_i = 1'b0;
        frame_done_i = 1'b0; req_i = 1'b0; slot_time_i = 16'd512;
        tick(4);
        // R10: reset state
        check(valid_o == 1'b0, "R10 valid_o in reset", valid_o, 0);
        check(r_o == '0, "R10 r_o in reset", r_o, 0);
        check(backoff_o == '0, "R10 backoff_o in reset", backoff_o, 0);
        rst_n = 1'b1;
        tick(1);
        check(valid_o == 1'b0 && r_o == '0, "R10 after release", r_o, 0);

        // R2: internal mode with n = 0 gives r = 0
        pulse_req(100);
        check(valid_o == 1'b1, "R2 n0 strobe", valid_o, 1);
        check(r_o == '0, "R2 n0 zero", r_o, 0);
        tick(3);

        // R3: external mode, every n from 1 to 16
        track_i = 1'b0;
        for (int n = 1; n <= 16; n++) begin
            coll_cnt_i = 4'(n - 1);
            for (int j = 0; j < 24; j++) begin
                pulse_req(37 * j + n);
                if (n < 16)
                    check(int'(r_o) < (1 << kexp(n)), "R3 external range", r_o, (1 << kexp(n)) - 1);
                else
                    check(valid_o == 1'b0, "R6 external excess refuse", valid_o, 0);
                if (j[0]) tick(1 + (j % 3));
            end
        end
        // R9: full range seen for n >= 10
        check(seen_high > 0, "R9 upper half reached", seen_high, 1);

        // R4: internal tracking through sixteen collisions
        track_i = 1'b1;
        frame_done_i = 1'b1; tick(1); frame_done_i = 1'b0;
        for (int c = 1; c <= 16; c++) begin
            coll_pulse_i = 1'b1; tick(1); coll_pulse_i = 1'b0;
            check(exc_coll_o == (c >= 16), "R4 excess at sixteenth", exc_coll_o, c >= 16);
            for (int j = 0; j < 6; j++) begin
                pulse_req(1000 + c * 7 + j);
                if (c < 16)
                    check(int'(r_o) < (1 << kexp(c)), "R4 internal range", r_o, (1 << kexp(c)) - 1);
                else
                    check(valid_o == 1'b0, "R6 internal excess refuse", valid_o, 0);
            end
        end
        // saturation: more collisions keep the error
        coll_pulse_i = 1'b1; tick(3); coll_pulse_i = 1'b0;
        check(exc_coll_o == 1'b1, "R4 saturate at 16", exc_coll_o, 1);
        // frame done wins over a simultaneous collision
        coll_pulse_i = 1'b1; frame_done_i = 1'b1; tick(1);
        coll_pulse_i = 1'b0; frame_done_i = 1'b0;
        check(exc_coll_o == 1'b0, "R4 done priority", exc_coll_o, 0);
        pulse_req(9);
        check(r_o == '0, "R4 cleared count gives zero", r_o, 0);

        // R7/R8: back-to-back requests with large slot times
        coll_pulse_i = 1'b1; tick(12); coll_pulse_i = 1'b0;
        req_i = 1'b1;
        for (int j = 0; j < 8; j++) begin
            slot_time_i = 16'(65535 - j * 4099);
            tick(1);
        end
        req_i = 1'b0;
        tick(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule